// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of 24-bit audio samples into a serial audio bit stream. One serializer covers six framing styles, selected by a 3-bit format code: single-slot mono (plain or with a one-bit late start), two-slot PCM, two-slot I2S, and multi-slot TDM (plain or late) with one to eight slots per frame. Every slot is 32 bit clocks long. It carries 24 sample bits, most significant first, and then 8 zero bits.

The block can drive the bit clock and frame clock itself, dividing its system clock by a parameter. It can also follow externally supplied clocks, which it synchronizes and edge-detects in the system clock domain. Either clock can be inverted, with separate inversion controls for driven clocks and for followed clocks. Samples come from a ready/valid-style FIFO head. The block takes one sample at the start of every slot. If the FIFO is empty at that point, it sends a silent slot and flags an underrun.

Top module: `aud_ser_tx`

## Requirements
- R1: `fmt_code_i` selects the slots per frame: codes 2 (PCM) and 3 (I2S) use 2 slots; codes 4 and 5 (TDM) use `slot_cnt_m1_i`+1 slots (1 to 8); codes 0 and 1 (mono) use 1 slot; the unused codes 6 and 7 behave as mono code 0.
- R2: Each slot spans 32 bit-clock periods. Bits 0..23 of the slot carry the sample MSB first (bit 23 of the sample first), and bits 24..31 are zero.
- R3: For codes 1, 3 and 5, slot bit 0 falls on frame bit position 1, one bit clock after the frame start. For codes 0, 2 and 4, it falls on position 0.
- R4: A frame has slots×32 bit positions. The non-inverted frame clock is low for positions below slots×16 and high for the rest. The frame starts where the frame clock goes high to low, as seen at a rising bit-clock edge.
- R5: When driving the clocks (`master_i`=1), the bit clock period is 2×HALF_DIV system clocks. Data and frame clock change after a falling edge of the non-inverted bit clock and hold across the rising edge.
- R6: `clk_inv_i` bit 3 inverts the driven frame clock, bit 2 inverts the driven bit clock, bit 1 inverts the followed external frame clock, and bit 0 inverts the followed external bit clock.
- R7: When following (`master_i`=0), the block times its bits from `ext_bclk_i` and `ext_fclk_i`. It stays silent until the first frame start and holds `bclk_o` and `fclk_o` low.
- R8: At each slot start with `smp_valid_i`=1, `smp_pop_o` pulses for one system clock and that sample is sent in the slot. Samples are sent in FIFO order, each exactly once.
- R9: At a slot start with `smp_valid_i`=0, the slot is all zero and `underrun_o` pulses for one system clock.
- R10: During reset, `sdata_o`, `smp_pop_o` and `underrun_o` are 0. In driving mode, `bclk_o` equals `clk_inv_i[2]` and `fclk_o` equals the inverse of `clk_inv_i[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_code_i | input | 3 | Framing format code |
| slot_cnt_m1_i | input | 3 | TDM slot count minus one |
| master_i | input | 1 | 1: drive bit and frame clocks; 0: follow external clocks |
| clk_inv_i | input | 4 | Clock inversion controls (see R6) |
| ext_bclk_i | input | 1 | External bit clock (follow mode) |
| ext_fclk_i | input | 1 | External frame clock (follow mode) |
| smp_valid_i | input | 1 | FIFO head holds a sample |
| smp_data_i | input | 24 | FIFO head sample |
| smp_pop_o | output | 1 | Sample taken from the FIFO head |
| underrun_o | output | 1 | Slot started with an empty FIFO |
| sdata_o | output | 1 | Serial data |
| bclk_o | output | 1 | Driven bit clock (low in follow mode) |
| fclk_o | output | 1 | Driven frame clock (low in follow mode) |

## Verification
The assertions take four things for granted:
- Format, slot count, mode and inversion inputs change only while reset is held.
- In follow mode, each external bit-clock half period lasts several system clocks, so that synchronized edges never merge.
- The external frame clock moves only at falling bit-clock edges and keeps the framing of R4.
- The FIFO head holds still between pops.

The stimulus reconfigures the block only under reset. It drives external clocks with six-system-clock half periods, with the frame clock updated at each falling edge. A bench FIFO model changes its head only at the clock edge that follows a pop.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;

    typedef enum logic [2:0] {
        FMT_MONO      = 3'd0,
        FMT_MONO_LATE = 3'd1,
        FMT_PCM       = 3'd2,
        FMT_I2S       = 3'd3,
        FMT_TDM       = 3'd4,
        FMT_TDM_LATE  = 3'd5
    } fmt_e;

    localparam int CNT_W     = 3;
    localparam int MAX_SLOTS = 1 << CNT_W;

    // R1: slots per frame for a format code
    function automatic logic [CNT_W:0] slots_of(input logic [2:0] code,
                                                input logic [CNT_W-1:0] nm1);
        case (code)
            FMT_PCM, FMT_I2S:      return (CNT_W+1)'(2);
            FMT_TDM, FMT_TDM_LATE: return {1'b0, nm1} + (CNT_W+1)'(1);
            default:               return (CNT_W+1)'(1);
        endcase
    endfunction

    // R3: formats whose MSB starts one bit after the frame start
    function automatic logic late_msb(input logic [2:0] code);
        return (code == FMT_MONO_LATE) || (code == FMT_I2S) || (code == FMT_TDM_LATE);
    endfunction

endpackage

// File: rtl/aud_ser_clk.sv
`timescale 1ns/1ps
module aud_ser_clk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic inv_bit_ext_i,
    input  logic inv_frm_ext_i,
    input  logic ext_bclk_i,
    input  logic ext_fclk_i,
    output logic shift_o,
    output logic fstart_o,
    output logic bclk_lvl_o
);

    localparam int DIV_W = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
        logic [1:0]       sb;
        logic [1:0]       sf;
        logic             bprev;
        logic             fr;
    } clk_st_t;

    localparam clk_st_t RST = '{cnt: '0, bclk: 1'b0, sb: 2'b00, sf: 2'b00,
                                bprev: 1'b0, fr: 1'b0};

    clk_st_t st_d, st_q;
    logic    b_now, f_now;

    always_comb begin
        st_d     = st_q;
        shift_o  = 1'b0;
        fstart_o = 1'b0;
        b_now    = st_q.sb[1] ^ inv_bit_ext_i;
        f_now    = st_q.sf[1] ^ inv_frm_ext_i;
        st_d.sb    = {st_q.sb[0], ext_bclk_i};
        st_d.sf    = {st_q.sf[0], ext_fclk_i};
        st_d.bprev = b_now;
        if (master_i) begin
            // R5: divider toggles the bit clock every HALF_DIV cycles
            if (st_q.cnt == DIV_W'(HALF_DIV - 1)) begin
                st_d.cnt  = '0;
                st_d.bclk = ~st_q.bclk;
                shift_o   = st_q.bclk;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end else begin
            // R7: follow synchronized external clocks
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
            if (st_q.bprev && !b_now) begin
                shift_o = 1'b1;
            end
            if (!st_q.bprev && b_now) begin
                st_d.fr  = f_now;
                fstart_o = st_q.fr && !f_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_lvl_o = st_q.bclk;

    // R5: shift events are isolated single-cycle pulses
    a_r5_shift_gap: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !shift_o);

    // R7: frame start and bit shift never coincide
    a_r7_start_not_shift: assert property (@(posedge clk) disable iff (!rst_n)
        fstart_o |-> !shift_o);

endmodule

// File: rtl/aud_ser_shift.sv
`timescale 1ns/1ps
module aud_ser_shift
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_i,
    input  logic [2:0]          fmt_code_i,
    input  logic [CNT_W-1:0]    slot_cnt_m1_i,
    input  logic                shift_i,
    input  logic                fstart_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic                sdata_o,
    output logic                fclk_raw_o,
    output logic                smp_pop_o,
    output logic                underrun_o
);

    localparam int POS_W  = $clog2(MAX_SLOTS * SLOT_BITS);
    localparam int SLOT_W = $clog2(SLOT_BITS);

    typedef struct packed {
        logic [POS_W-1:0]    pos;
        logic [SAMPLE_W-1:0] sreg;
        logic                sdata;
        logic                fclk;
        logic                locked;
    } sh_st_t;

    localparam sh_st_t RST = '{pos: '1, sreg: '0, sdata: 1'b0, fclk: 1'b1,
                               locked: 1'b0};

    sh_st_t             st_d, st_q;
    logic [CNT_W:0]     slots;
    logic               late;
    logic [POS_W-1:0]   frame_last, half_pos, pos_nx;
    logic [SLOT_W-1:0]  bit_nx, bit_cur;

    always_comb begin
        slots      = slots_of(fmt_code_i, slot_cnt_m1_i);
        late       = late_msb(fmt_code_i);
        frame_last = POS_W'(32'(slots) * SLOT_BITS - 1);
        half_pos   = POS_W'(32'(slots) * (SLOT_BITS / 2));
        pos_nx     = (st_q.pos >= frame_last) ? '0 : st_q.pos + POS_W'(1);
        bit_nx     = pos_nx[SLOT_W-1:0] - SLOT_W'(late);
        bit_cur    = st_q.pos[SLOT_W-1:0] - SLOT_W'(late);

        st_d       = st_q;
        smp_pop_o  = 1'b0;
        underrun_o = 1'b0;
        if (fstart_i) begin
            // R7: lock frame position on the external frame start
            st_d.locked = 1'b1;
            st_d.pos    = '0;
        end else if (shift_i && (st_q.locked || master_i)) begin
            st_d.pos  = pos_nx;
            st_d.fclk = (pos_nx >= half_pos);
            if (bit_nx == '0) begin
                if (smp_valid_i) begin
                    smp_pop_o  = 1'b1;
                    st_d.sdata = smp_data_i[SAMPLE_W-1];
                    st_d.sreg  = smp_data_i << 1;
                end else begin
                    underrun_o = 1'b1;
                    st_d.sdata = 1'b0;
                    st_d.sreg  = '0;
                end
            end else begin
                st_d.sdata = st_q.sreg[SAMPLE_W-1];
                st_d.sreg  = st_q.sreg << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o    = st_q.sdata;
    assign fclk_raw_o = st_q.fclk;

    // R2: the padding bits of a slot are always zero
    a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cur >= SLOT_W'(SAMPLE_W)) |-> !st_q.sdata);

    // R3: a slot load lands on the slot's first data position
    a_r3_load_point: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_pop_o || underrun_o) |=> (st_q.pos[SLOT_W-1:0] == SLOT_W'(late)));

    // R4: the driven frame clock only moves at frame start or mid-frame
    a_r4_fclk_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && (st_q.fclk != $past(st_q.fclk)))
            |-> (st_q.pos == '0 || st_q.pos == half_pos));

    // R5: serial data changes only after a shift event
    a_r5_sdata_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sdata != $past(st_q.sdata)) |-> $past(shift_i));

    // R8: a popped sample's MSB appears on the line next
    a_r8_pop_msb: assert property (@(posedge clk) disable iff (!rst_n)
        smp_pop_o |=> (st_q.sdata == $past(smp_data_i[SAMPLE_W-1])));

    // R9: an underrun slot starts with a zero bit
    a_r9_under_zero: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !st_q.sdata);

endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_code_i,
    input  logic [2:0]          slot_cnt_m1_i,
    input  logic                master_i,
    input  logic [3:0]          clk_inv_i,
    input  logic                ext_bclk_i,
    input  logic                ext_fclk_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic                smp_pop_o,
    output logic                underrun_o,
    output logic                sdata_o,
    output logic                bclk_o,
    output logic                fclk_o
);

    logic shift, fstart, bclk_lvl, fclk_raw;

    aud_ser_clk #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_i      (master_i),
        .inv_bit_ext_i (clk_inv_i[0]),
        .inv_frm_ext_i (clk_inv_i[1]),
        .ext_bclk_i    (ext_bclk_i),
        .ext_fclk_i    (ext_fclk_i),
        .shift_o       (shift),
        .fstart_o      (fstart),
        .bclk_lvl_o    (bclk_lvl)
    );

    aud_ser_shift #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_i      (master_i),
        .fmt_code_i    (fmt_code_i),
        .slot_cnt_m1_i (slot_cnt_m1_i),
        .shift_i       (shift),
        .fstart_i      (fstart),
        .smp_valid_i   (smp_valid_i),
        .smp_data_i    (smp_data_i),
        .sdata_o       (sdata_o),
        .fclk_raw_o    (fclk_raw),
        .smp_pop_o     (smp_pop_o),
        .underrun_o    (underrun_o)
    );

    // R6 / R7: driven clocks with master inversion, quiet when following
    assign bclk_o = master_i & (bclk_lvl ^ clk_inv_i[2]);
    assign fclk_o = master_i & (fclk_raw ^ clk_inv_i[3]);

endmodule

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_code = '0;
    logic [2:0]  nm1 = '0;
    logic        master = 1'b1;
    logic [3:0]  inv = '0;
    logic        ext_b = 1'b1;
    logic        ext_f = 1'b1;
    logic        fifo_v = 1'b0;
    logic [23:0] fifo_d = '0;
    logic        pop, under, sdata, bclk, fclk;

    always #5 clk = ~clk;

    aud_ser_tx #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_code_i(fmt_code), .slot_cnt_m1_i(nm1),
        .master_i(master), .clk_inv_i(inv), .ext_bclk_i(ext_b), .ext_fclk_i(ext_f),
        .smp_valid_i(fifo_v), .smp_data_i(fifo_d), .smp_pop_o(pop),
        .underrun_o(under), .sdata_o(sdata), .bclk_o(bclk), .fclk_o(fclk)
    );

    int checks = 0, fails = 0;
    logic [23:0] fq[$], sent[$], rx[$];
    int pops, unders, early_under, S;

    // FIFO head model: head advances at the edge that consumes it
    always @(posedge clk) begin
        if (pop && fq.size() > 0) begin
            void'(fq.pop_front());
            pops++;
        end
        if (under) begin
            unders++;
            if (pops < S) early_under++;
        end
        fifo_v <= (fq.size() > 0);
        fifo_d <= (fq.size() > 0) ? fq[0] : 24'h0;
    end

    // receiver model
    bit mon_on = 0, slv = 0, started = 0, seen_rise = 0;
    int p, fl, dly, cyc, frames, per_err, len_err, fck_err, tail_err, quiet_err;
    logic prev_b, prev_f;
    logic [23:0] word;

    always @(negedge clk) begin
        logic b, f;
        int sb;
        if (mon_on) begin
            b = slv ? (ext_b ^ inv[0]) : (bclk ^ inv[2]);
            f = slv ? (ext_f ^ inv[1]) : (fclk ^ inv[3]);
            if (slv && (bclk || fclk)) quiet_err++;
            cyc++;
            if (b && !prev_b) begin
                if (!slv && seen_rise && cyc != 2 * HALF) per_err++;
                seen_rise = 1;
                cyc = 0;
                if (prev_f && !f) begin
                    if (started && p != fl - 1) len_err++;
                    p = 0;
                    started = 1;
                    frames++;
                end else begin
                    p++;
                end
                if (started) begin
                    sb = (p - dly) & 31;
                    if (f != (p >= fl / 2)) fck_err++;
                    if (sb == 0) word = '0;
                    if (sb < 24) word[23 - sb] = sdata;
                    else if (sdata) tail_err++;
                    if (sb == 23) rx.push_back(word);
                end
                prev_f = f;
            end
            prev_b = b;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_slots(input logic [2:0] c, input logic [2:0] n);
        if (c == 3'd2 || c == 3'd3) return 2;
        if (c == 3'd4 || c == 3'd5) return int'(n) + 1;
        return 1;
    endfunction

    function automatic logic [23:0] corner(input int i);
        case (i)
            0: return 24'h800000;
            1: return 24'h000001;
            2: return 24'hFFFFFF;
            default: return 24'h555555;
        endcase
    endfunction

    task automatic drive_ext(input int fl_i, input int nf, input logic [3:0] iv);
        for (int fr = -1; fr < nf; fr++) begin
            for (int pp = (fr < 0) ? fl_i - 1 : 0; pp < fl_i; pp++) begin
                @(negedge clk); #2;
                ext_b = iv[0];
                ext_f = (pp >= fl_i / 2) ^ iv[1];
                repeat (6) @(negedge clk);
                #2;
                ext_b = ~iv[0];
                repeat (5) @(negedge clk);
            end
        end
    endtask

    task automatic run_cfg(input string tag, input logic [2:0] code, input logic [2:0] n,
                           input bit slave_mode, input logic [3:0] iv, input int nf,
                           input bit directed);
        int slots, idx, mism, zbad;
        slots = exp_slots(code, n);
        @(negedge clk);
        rst_n = 1'b0;
        mon_on = 0;
        fmt_code = code;
        nm1 = n;
        master = !slave_mode;
        inv = iv;
        ext_b = ~iv[0];
        ext_f = ~iv[1];
        fq.delete(); sent.delete(); rx.delete();
        pops = 0; unders = 0; early_under = 0;
        S = slots * (nf - 2);
        for (int i = 0; i < S; i++) begin
            logic [23:0] v;
            v = (directed && i < 4) ? corner(i) : (24'($urandom) | 24'h000100);
            fq.push_back(v);
            sent.push_back(v);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sdata == 0 && !pop && !under, "R10", {tag, " reset data/pop/underrun"},
              {sdata, pop, under}, 0);
        if (!slave_mode)
            check(bclk == iv[2] && fclk == !iv[3], "R10", {tag, " reset clocks"},
                  {bclk, fclk}, {iv[2], !iv[3]});
        else
            check(!bclk && !fclk, "R7", {tag, " reset quiet clocks"}, {bclk, fclk}, 0);
        fl = slots * 32;
        dly = (code == 3'd1 || code == 3'd3 || code == 3'd5) ? 1 : 0;
        slv = slave_mode;
        prev_b = slave_mode ? (ext_b ^ iv[0]) : (bclk ^ iv[2]);
        prev_f = 0; p = 0; started = 0; seen_rise = 0; cyc = 0; frames = 0;
        per_err = 0; len_err = 0; fck_err = 0; tail_err = 0; quiet_err = 0;
        mon_on = 1;
        rst_n = 1'b1;
        if (slave_mode) drive_ext(fl, nf, iv);
        else while (frames < nf) @(negedge clk);
        repeat (2) @(negedge clk);
        mon_on = 0;

        idx = 0;
        while (idx < rx.size() && rx[idx] == 0) idx++;
        mism = 0;
        for (int i = 0; i < S; i++)
            if (idx + i >= rx.size() || rx[idx + i] != sent[i]) mism++;
        check(mism == 0, "R2", {tag, " slot words vs samples (mismatches)"}, mism, 0);
        check(idx <= ((slave_mode && dly == 0) ? 1 : 0), "R3", {tag, " leading silent slots"},
              idx, 0);
        zbad = 0;
        for (int i = idx + S; i < rx.size(); i++) if (rx[i] != 0) zbad++;
        check(zbad == 0 && rx.size() > idx + S, "R9", {tag, " silent slots after drain"},
              zbad, 0);
        check(unders > 0 && early_under == 0, "R9", {tag, " underrun pulses (early)"},
              early_under, 0);
        check(pops == S && fq.size() == 0, "R8", {tag, " samples popped"}, pops, S);
        check(fck_err == 0 && len_err == 0, "R4", {tag, " frame clock shape/length"},
              fck_err + len_err, 0);
        check(tail_err == 0, "R2", {tag, " zero padding bits"}, tail_err, 0);
        check(frames >= nf - 1, "R1", {tag, " frames decoded"}, frames, nf);
        if (!slave_mode)
            check(per_err == 0, "R5", {tag, " bit clock period"}, per_err, 0);
        else
            check(quiet_err == 0, "R7", {tag, " driven clocks quiet"}, quiet_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        run_cfg("R1 R2 R8 mono",        3'd0, 3'd0, 0, 4'b0000, 8, 1);
        run_cfg("R3 R6 mono-late inv",  3'd1, 3'd0, 0, 4'b1100, 8, 0);
        run_cfg("R2 pcm",               3'd2, 3'd0, 0, 4'b0000, 6, 1);
        run_cfg("R3 R6 i2s bclk-inv",   3'd3, 3'd0, 0, 4'b0100, 6, 0);
        run_cfg("R1 tdm8",              3'd4, 3'd7, 0, 4'b0000, 4, 0);
        run_cfg("R3 R6 tdm3-late",      3'd5, 3'd2, 0, 4'b1000, 5, 0);
        run_cfg("R1 code6 as mono",     3'd6, 3'd5, 0, 4'b0000, 6, 0);
        run_cfg("R7 R6 ext i2s inv",    3'd3, 3'd0, 1, 4'b0011, 5, 0);
        run_cfg("R7 ext tdm4",          3'd4, 3'd3, 1, 4'b0000, 4, 0);
        run_cfg("R7 R6 ext mono",       3'd0, 3'd0, 1, 4'b0001, 6, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule